// File: doc/BRIEF.md
# Signed-Magnitude Accumulating Adder/Subtractor

This unit adds or subtracts two integers held as a sign bit plus an unsigned magnitude. It captures both operands when `start` is pulsed while the unit is idle. The first operand's magnitude and sign registers act as the accumulator. After a few clock cycles they hold the result, and `done` pulses for one cycle.

A sign-relation decision picks one of two paths. On the magnitude-sum path, the magnitudes are summed, the carry out becomes the overflow flag, and the result keeps the first operand's sign. On the difference path, the second magnitude is subtracted by adding its one's complement plus one. A missing carry means the difference went negative. The accumulator is then complemented in one cycle and incremented in the next, and its sign is inverted. An exact cancellation always yields positive zero.

The number of cycles depends on the path taken. Inputs are disregarded while the unit is busy. Results hold until the next accepted start.

Top module: `sm_addsub`

## Requirements
- R1: After reset, `res_mag` is 0, `res_sign` is 0, `ovf` is 0 and `done` is 0.
- R2: The magnitude-sum path is taken when the operation is add (`sub_op`=0) with equal signs, or subtract (`sub_op`=1) with different signs. On this path, `res_mag` is (a_mag+b_mag) mod 2^W and `res_sign` equals `a_sign`. `done` is high 2 rising edges after the edge that accepts `start`.
- R3: On the magnitude-sum path, `ovf` is 1 exactly when a_mag+b_mag ≥ 2^W. On the difference path, `ovf` is 0.
- R4: On the difference path with a_mag > b_mag, `res_mag` is a_mag−b_mag and `res_sign` is `a_sign`. `done` is high 3 edges after acceptance.
- R5: On the difference path with a_mag < b_mag, `res_mag` is b_mag−a_mag and `res_sign` is the inverse of `a_sign`. `done` is high 4 edges after acceptance; the extra two cycles are a complement step followed by an increment step.
- R6: On the difference path with a_mag = b_mag, the result is magnitude 0 with sign 0 (never negative zero). `done` is high 3 edges after acceptance.
- R7: `done` is high for exactly one cycle. The result outputs then hold their values until another start is accepted.
- R8: `start` is accepted only while idle. A `start` asserted while an operation is in progress, or while `done` is high, is ignored and does not alter the result.
- R9: On the magnitude-sum path, when both magnitudes are zero the result sign is `a_sign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| sub_op | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of first operand (1 = negative) |
| a_mag | input | W | Magnitude of first operand |
| b_sign | input | 1 | Sign of second operand |
| b_mag | input | W | Magnitude of second operand |
| res_mag | output | W | Result magnitude (accumulator) |
| res_sign | output | 1 | Result sign |
| ovf | output | 1 | Magnitude-sum overflow |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with W=4. At that width, every pair of magnitudes combined with all four sign pairs and both operations can be run exhaustively: 2048 operations covering all eight sign/operation cases. This sweep reaches every overflow boundary, every exact cancellation, both zero operands and the complement-and-increment path. Each result is compared against signed integer arithmetic, and the completion latency is checked for every operation.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_EXEC = 3'd1,
    ST_FIX  = 3'd2,
    ST_INC  = 3'd3,
    ST_DONE = 3'd4
  } sm_state_t;

  // Magnitude-sum path is chosen when the sign relation matches the operation.
  function automatic logic sel_sum_path(input logic op_sub, input logic sa, input logic sb);
    return ((sa ^ sb) == op_sub);
  endfunction
endpackage

// File: rtl/sm_path_sel.sv
module sm_path_sel (
  input  logic op_sub,
  input  logic sa,
  input  logic sb,
  output logic sum_path
);
  import sm_pkg::*;
  always_comb sum_path = sel_sum_path(op_sub, sa, sb);
endmodule

// File: rtl/sm_mag_unit.sv
module sm_mag_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         diff,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int XW = W + 1;
  logic [W-1:0]  y_eff;
  logic [XW-1:0] wide;

  always_comb begin
    y_eff = diff ? ~y : y;
    wide  = {1'b0, x} + {1'b0, y_eff} + {{(XW-1){1'b0}}, diff};
    sum   = wide[W-1:0];
    cout  = wide[W];
  end
endmodule

// File: rtl/sm_seq_ctrl.sv
module sm_seq_ctrl (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sum_path,
  input  logic               e_bit,
  output sm_pkg::sm_state_t  state
);
  import sm_pkg::*;
  sm_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_EXEC;
      ST_EXEC: nxt = sum_path ? ST_DONE : ST_FIX;
      ST_FIX:  nxt = e_bit ? ST_DONE : ST_INC;
      ST_INC:  nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sub_op,
  input  logic         a_sign,
  input  logic [W-1:0] a_mag,
  input  logic         b_sign,
  input  logic [W-1:0] b_mag,
  output logic [W-1:0] res_mag,
  output logic         res_sign,
  output logic         ovf,
  output logic         done
);
  import sm_pkg::*;

  logic [W-1:0] acc_q, opb_q;
  logic         accs_q, opbs_q, op_q, e_q, avf_q;
  sm_state_t    state;

  // Named internal events, used by the checker.
  logic         sum_path;
  logic [W-1:0] alu_sum;
  logic         alu_cout;
  logic         st_idle, st_exec, st_fix, st_inc;
  logic         accept;

  assign st_idle = (state == ST_IDLE);
  assign st_exec = (state == ST_EXEC);
  assign st_fix  = (state == ST_FIX);
  assign st_inc  = (state == ST_INC);
  assign accept  = st_idle & start;

  sm_path_sel u_path (
    .op_sub   (op_q),
    .sa       (accs_q),
    .sb       (opbs_q),
    .sum_path (sum_path)
  );

  sm_mag_unit #(.W(W)) u_mag (
    .x    (acc_q),
    .y    (opb_q),
    .diff (~sum_path),
    .sum  (alu_sum),
    .cout (alu_cout)
  );

  sm_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sum_path (sum_path),
    .e_bit    (e_q),
    .state    (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      accs_q <= 1'b0;
      opb_q  <= '0;
      opbs_q <= 1'b0;
      op_q   <= 1'b0;
      e_q    <= 1'b0;
      avf_q  <= 1'b0;
    end else begin
      if (accept) begin
        acc_q  <= a_mag;
        accs_q <= a_sign;
        opb_q  <= b_mag;
        opbs_q <= b_sign;
        op_q   <= sub_op;
        avf_q  <= 1'b0;
      end
      if (st_exec) begin
        acc_q <= alu_sum;
        e_q   <= alu_cout;
        avf_q <= sum_path & alu_cout;
      end
      if (st_fix) begin
        if (!e_q) begin
          acc_q  <= ~acc_q;
          accs_q <= ~accs_q;
        end else if (acc_q == '0) begin
          accs_q <= 1'b0;
        end
      end
      if (st_inc) acc_q <= acc_q + {{(W-1){1'b0}}, 1'b1};
    end
  end

  assign res_mag  = acc_q;
  assign res_sign = accs_q;
  assign ovf      = avf_q;
  assign done     = (state == ST_DONE);
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic         ovf,
  input logic         res_sign,
  input logic [W-1:0] res_mag,
  input logic         sum_path,
  input logic         st_idle,
  input logic         st_exec,
  input logic         st_inc
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(res_mag) && $stable(res_sign)));

  p_diff_no_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_exec && !sum_path) |=> !ovf);

  p_sum_keeps_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_exec && sum_path) |=> ($stable(res_sign) && done));

  p_no_neg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sum_path) |-> !(res_sign && (res_mag == '0)));

  p_inc_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_inc |=> (done && $stable(res_sign)));

  p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_idle && !done && start) |=> !st_exec);
endmodule

bind sm_addsub sm_addsub_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .ovf      (ovf),
  .res_sign (res_sign),
  .res_mag  (res_mag),
  .sum_path (sum_path),
  .st_idle  (st_idle),
  .st_exec  (st_exec),
  .st_inc   (st_inc)
);

// File: tb/sm_addsub_bench.sv
module sm_addsub_bench;
  localparam int W      = 4;
  localparam int CLK_NS = 10;
  localparam int MAXV   = (1 << W);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, sub_op = 1'b0, a_sign = 1'b0, b_sign = 1'b0;
  logic [W-1:0] a_mag = '0, b_mag = '0;
  logic [W-1:0] res_mag;
  logic         res_sign, ovf, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sm_addsub #(.W(W)) u_sm_addsub (
    .clk(clk), .rst_n(rst_n), .start(start), .sub_op(sub_op),
    .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
    .res_mag(res_mag), .res_sign(res_sign), .ovf(ovf), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: plain signed integer arithmetic.
  task automatic expect_of(input bit s, input bit as, input int am, input bit bs,
                           input int bm, output int emag, output bit esgn,
                           output bit eovf, output int elat, output string req);
    int va, vb, r, ar;
    bit sump;
    va = as ? -am : am;
    vb = bs ? -bm : bm;
    r  = s ? va - vb : va + vb;
    ar = (r < 0) ? -r : r;
    sump = s ? (as != bs) : (as == bs);
    emag = ar % MAXV;
    eovf = (ar >= MAXV);
    if (r < 0)       esgn = 1'b1;
    else if (r == 0) esgn = sump ? as : 1'b0;
    else             esgn = 1'b0;
    elat = sump ? 2 : ((am >= bm) ? 3 : 4);
    if (sump)          req = eovf ? "R3" : ((am == 0 && bm == 0) ? "R9" : "R2");
    else if (am == bm) req = "R6";
    else if (am > bm)  req = "R4";
    else               req = "R5";
  endtask

  // Drive at negedge; count rising edges until done observed at a negedge.
  task automatic run_op(input bit s, input bit as, input int am, input bit bs,
                        input int bm, input int noise_cycles);
    int emag, elat, n;
    bit esgn, eovf;
    string req;
    expect_of(s, as, am, bs, bm, emag, esgn, eovf, elat, req);
    @(negedge clk);
    sub_op = s; a_sign = as; a_mag = W'(am); b_sign = bs; b_mag = W'(bm); start = 1'b1;
    n = 0;
    @(posedge clk); n++;
    @(negedge clk);
    if (noise_cycles > 0) begin
      // R8: busy-time start with other operands must be ignored.
      sub_op = ~s; a_sign = ~as; a_mag = ~W'(am); b_mag = W'(bm + 3);
    end else start = 1'b0;
    while (!done && n < 20) begin
      if (n >= noise_cycles) start = 1'b0;
      @(posedge clk); n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == elat, (noise_cycles > 0) ? "R8" : req, "latency", n, elat);
    chk(res_mag == W'(emag), (noise_cycles > 0) ? "R8" : req, "res_mag", int'(res_mag), emag);
    chk(res_sign == esgn, (noise_cycles > 0) ? "R8" : req, "res_sign", int'(res_sign), int'(esgn));
    chk(ovf == eovf, (noise_cycles > 0) ? "R8" : "R3", "ovf", int'(ovf), int'(eovf));
  endtask

  task automatic t_reset();
    chk(res_mag == '0, "R1", "res_mag", int'(res_mag), 0);
    chk(res_sign == 1'b0, "R1", "res_sign", int'(res_sign), 0);
    chk(ovf == 1'b0, "R1", "ovf", int'(ovf), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
  endtask

  task automatic t_exhaustive();
    for (int s = 0; s < 2; s++)
      for (int sg = 0; sg < 4; sg++)
        for (int am = 0; am < MAXV; am++)
          for (int bm = 0; bm < MAXV; bm++)
            run_op(s[0], sg[1], am, sg[0], bm, 0);
  endtask

  task automatic t_done_pulse_hold();
    logic [W-1:0] m;
    logic sg;
    run_op(1'b0, 1'b1, 5, 1'b0, 9, 0);   // R5 case: -5 + 9 = +4
    m = res_mag; sg = res_sign;
    @(negedge clk);
    chk(done == 1'b0, "R7", "done second cycle", int'(done), 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(done == 1'b0 && res_mag == m && res_sign == sg, "R7", "hold res_mag",
        int'(res_mag), int'(m));
  endtask

  task automatic t_busy_ignore();
    run_op(1'b1, 1'b0, 3, 1'b0, 11, 3);   // 3 - 11 = -8, noise for 3 cycles
    run_op(1'b0, 1'b0, 9, 1'b0, 9, 1);    // 9 + 9 = 18 -> ovf, mag 2
    run_op(1'b1, 1'b1, 7, 1'b1, 7, 2);    // -7 - -7 = +0
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exhaustive();
    t_done_pulse_hold();
    t_busy_ignore();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule